// File: doc/BRIEF.md
# Store Address and Base Update Generator

This block sits in the store path of a processor pipeline. It takes the base register, an immediate or a shifted index register as the offset, and the indexing controls, and it produces the address the store writes to. It also produces the value the base register should take afterwards and a strobe that asks for that base write. The three kinds of single store (plain, exclusive and paired-word) share one adder path. The save-state store uses its own stack-relative address path.

Requests arrive with a valid bit. All results are registered and appear one cycle later. Memory access, alignment checks and data formatting are handled elsewhere.

Top module: `stw_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `base_wr`, `eff_addr` and `new_base` are all zero.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. When `out_valid` is low, `base_wr` is low.
- R3: For plain (`op_class`=0) and paired (`op_class`=2) stores with `pre_index`=0, `eff_addr` is the unmodified base.
- R4: For plain and paired stores with `pre_index`=1, `eff_addr` is base+offset when `add_dir`=1 and base−offset when `add_dir`=0.
- R5: For plain and paired stores, `base_wr` is 1 exactly when `wb_en`=1. `new_base` is then base±offset in the direction of `add_dir`, for both pre- and post-indexing. With `wb_en`=0, `new_base` is the base.
- R6: With `use_reg_off`=1, the offset is `idx_reg` shifted by `shift_amt`. `shift_kind` selects the shift: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. An amount of 0 leaves the value unshifted for kinds 0 to 2. With `use_reg_off`=0, the offset is `imm_off` zero-extended.
- R7: With `shift_kind`=3 and `shift_amt`=0, the offset is `idx_reg` shifted right by one bit, with `carry_in` entering at bit 31.
- R8: An exclusive store (`op_class`=1) ignores `pre_index`, `add_dir`, `wb_en` and `use_reg_off`. It uses `eff_addr` = base + zero-extended `imm_off`, keeps `base_wr` low and leaves `new_base` equal to the base.
- R9: A save-state store (`op_class`=3) uses `eff_addr` = `stack_ptr` + k. Here k starts at 0, gains 4 when `pre_index` equals `add_dir`, and loses 8 when `add_dir`=0.
- R10: A save-state store with `wb_en`=1 asserts `base_wr` and sets `new_base` to `stack_ptr`+8 when `add_dir`=1, or `stack_ptr`−8 when `add_dir`=0. With `wb_en`=0, `new_base` is `stack_ptr` and `base_wr` is low.
- R11: All address and base arithmetic wraps modulo 2^32, and no overflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_class | input | 2 | 0 plain, 1 exclusive, 2 paired, 3 save-state |
| base_val | input | 32 | Base register value |
| stack_ptr | input | 32 | Banked stack pointer for save-state stores |
| imm_off | input | 12 | Immediate offset, zero-extended |
| idx_reg | input | 32 | Index register for register offsets |
| shift_kind | input | 2 | Shift type for the index register |
| shift_amt | input | 5 | Shift amount |
| carry_in | input | 1 | Carry flag fed to the shifter |
| use_reg_off | input | 1 | 1 selects the shifted register offset |
| pre_index | input | 1 | 1 pre-indexed, 0 post-indexed |
| add_dir | input | 1 | 1 add offset, 0 subtract |
| wb_en | input | 1 | Request a base update |
| out_valid | output | 1 | Results valid |
| eff_addr | output | 32 | Effective store address |
| new_base | output | 32 | Updated base or stack pointer |
| base_wr | output | 1 | Base write strobe |

## Verification
Every result (`out_valid`, `eff_addr`, `new_base`, `base_wr`) is due exactly one clock edge after the request is presented. The bench drives each request on a falling edge and lets one rising edge pass. It then compares all four outputs on the following falling edge, against a model evaluated from the inputs it just drove. After a burst it drops `in_valid` and checks on the next falling edge that `out_valid` and `base_wr` have returned to zero.

// File: rtl/st_agen_pkg.sv
package st_agen_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_EXCL  = 2'd1,
    CLS_PAIR  = 2'd2,
    CLS_SAVE  = 2'd3
  } st_class_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;

  localparam int SAVE_STEP = 8;
  localparam int SAVE_SKEW = 4;
endpackage

// File: rtl/st_shifter.sv
module st_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [1:0]    kind,
  input  logic [SW-1:0] amt,
  input  logic          carry,
  output logic [W-1:0]  res
);
  import st_agen_pkg::*;

  // logarithmic rotate-right network
  logic [SW:0][W-1:0] rot;
  assign rot[0] = val;
  for (genvar g = 0; g < SW; g++) begin : g_rot
    localparam int S = 1 << g;
    assign rot[g+1] = amt[g] ? {rot[g][S-1:0], rot[g][W-1:S]} : rot[g];
  end

  always_comb begin
    case (kind)
      SH_LSL:  res = val << amt;
      SH_LSR:  res = val >> amt;
      SH_ASR:  res = W'($signed(val) >>> amt);
      default: res = (amt == '0) ? {carry, val[W-1:1]} : rot[SW];
    endcase
  end
endmodule

// File: rtl/st_index_calc.sv
module st_index_calc #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] off,
  input  logic         add_dir,
  input  logic         pre_index,
  output logic [W-1:0] ea,
  output logic [W-1:0] upd
);
  logic [W-1:0] moved;
  assign moved = add_dir ? (base + off) : (base - off);
  assign ea    = pre_index ? moved : base;
  assign upd   = moved;
endmodule

// File: rtl/st_save_calc.sv
module st_save_calc #(
  parameter int W = 32
) (
  input  logic [W-1:0] sp,
  input  logic         pre_index,
  input  logic         add_dir,
  output logic [W-1:0] ea,
  output logic [W-1:0] upd
);
  import st_agen_pkg::*;
  localparam logic [W-1:0] STEP = W'(SAVE_STEP);
  localparam logic [W-1:0] SKEW = W'(SAVE_SKEW);

  logic [W-1:0] skew;
  always_comb begin
    skew = '0;
    // post flag differs from add flag <=> pre flag equals add flag
    if (pre_index == add_dir) skew = skew + SKEW;
    if (!add_dir)             skew = skew - STEP;
  end

  assign ea  = sp + skew;
  assign upd = add_dir ? (sp + STEP) : (sp - STEP);
endmodule

// File: rtl/stw_addr_gen.sv
module stw_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         op_class,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  stack_ptr,
  input  logic [IMM_W-1:0]   imm_off,
  input  logic [ADDR_W-1:0]  idx_reg,
  input  logic [1:0]         shift_kind,
  input  logic [SHAMT_W-1:0] shift_amt,
  input  logic               carry_in,
  input  logic               use_reg_off,
  input  logic               pre_index,
  input  logic               add_dir,
  input  logic               wb_en,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  eff_addr,
  output logic [ADDR_W-1:0]  new_base,
  output logic               base_wr
);
  import st_agen_pkg::*;
  localparam int PAD_W = ADDR_W - IMM_W;

  logic              is_excl, is_save;
  logic [ADDR_W-1:0] imm_ext, shifted, offset;
  logic              pre_eff, add_eff, wb_eff;
  logic [ADDR_W-1:0] idx_ea, idx_upd, sv_ea, sv_upd;
  logic [ADDR_W-1:0] ea_d, nb_d;

  assign is_excl = (op_class == CLS_EXCL);
  assign is_save = (op_class == CLS_SAVE);
  assign imm_ext = {{PAD_W{1'b0}}, imm_off};

  st_shifter #(.W(ADDR_W), .SW(SHAMT_W)) u_shift (
    .val(idx_reg), .kind(shift_kind), .amt(shift_amt),
    .carry(carry_in), .res(shifted)
  );

  // exclusive stores force immediate, pre-indexed, add, no writeback
  assign offset  = (use_reg_off && !is_excl) ? shifted : imm_ext;
  assign pre_eff = is_excl ? 1'b1 : pre_index;
  assign add_eff = is_excl ? 1'b1 : add_dir;
  assign wb_eff  = is_excl ? 1'b0 : wb_en;

  st_index_calc #(.W(ADDR_W)) u_idx (
    .base(base_val), .off(offset), .add_dir(add_eff),
    .pre_index(pre_eff), .ea(idx_ea), .upd(idx_upd)
  );

  st_save_calc #(.W(ADDR_W)) u_save (
    .sp(stack_ptr), .pre_index(pre_index), .add_dir(add_dir),
    .ea(sv_ea), .upd(sv_upd)
  );

  always_comb begin
    if (is_save) begin
      ea_d = sv_ea;
      nb_d = wb_eff ? sv_upd : stack_ptr;
    end else begin
      ea_d = idx_ea;
      nb_d = wb_eff ? idx_upd : base_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      base_wr   <= 1'b0;
      eff_addr  <= '0;
      new_base  <= '0;
    end else begin
      out_valid <= in_valid;
      base_wr   <= in_valid & wb_eff;
      if (in_valid) begin
        eff_addr <= ea_d;
        new_base <= nb_d;
      end
    end
  end
endmodule

// File: rtl/st_agen_checks.sv
module st_agen_checks #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op_class,
  input logic [ADDR_W-1:0] base_val,
  input logic [ADDR_W-1:0] stack_ptr,
  input logic [IMM_W-1:0]  imm_off,
  input logic              pre_index,
  input logic              wb_en,
  input logic              out_valid,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [ADDR_W-1:0] new_base,
  input logic              base_wr
);
  localparam logic [ADDR_W-1:0] EIGHT = ADDR_W'(8);

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  assert_strobe_gated_R2: assert property (@(posedge clk) disable iff (rst)
    base_wr |-> out_valid);

  assert_post_base_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(op_class) == 2'd0 || $past(op_class) == 2'd2) && !$past(pre_index))
      |-> eff_addr == $past(base_val));

  assert_excl_fixed_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_class) == 2'd1)
      |-> (!base_wr && eff_addr == $past(base_val) + ADDR_W'($past(imm_off))));

  assert_save_step_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_class) == 2'd3 && $past(wb_en))
      |-> (base_wr && (new_base - $past(stack_ptr) == EIGHT ||
                       $past(stack_ptr) - new_base == EIGHT)));
endmodule

bind stw_addr_gen st_agen_checks #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
  .base_val(base_val), .stack_ptr(stack_ptr), .imm_off(imm_off),
  .pre_index(pre_index), .wb_en(wb_en), .out_valid(out_valid),
  .eff_addr(eff_addr), .new_base(new_base), .base_wr(base_wr)
);

// File: tb/stw_addr_gen_test.sv
module stw_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_class = '0;
  logic [31:0] base_val = '0, stack_ptr = '0, idx_reg = '0;
  logic [11:0] imm_off = '0;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  shift_amt = '0;
  logic        carry_in = 1'b0, use_reg_off = 1'b0;
  logic        pre_index = 1'b0, add_dir = 1'b0, wb_en = 1'b0;
  logic        out_valid, base_wr;
  logic [31:0] eff_addr, new_base;

  int errors = 0;
  int checks = 0;

  stw_addr_gen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
    .base_val(base_val), .stack_ptr(stack_ptr), .imm_off(imm_off),
    .idx_reg(idx_reg), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .carry_in(carry_in), .use_reg_off(use_reg_off), .pre_index(pre_index),
    .add_dir(add_dir), .wb_en(wb_en), .out_valid(out_valid),
    .eff_addr(eff_addr), .new_base(new_base), .base_wr(base_wr)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] ref_shift(logic [31:0] x, logic [1:0] k,
                                            logic [4:0] a, logic c);
    case (k)
      2'd0: return x << a;
      2'd1: return x >> a;
      2'd2: return 32'($signed(x) >>> a);
      default:
        if (a == 0) return {c, x[31:1]};
        else return (x >> a) | (x << (6'd32 - {1'b0, a}));
    endcase
  endfunction

  function automatic void model(output logic [31:0] ea, output logic [31:0] nb,
                                output logic bw);
    logic [31:0] off, moved, k;
    if (op_class == 2'd3) begin
      k = 0;
      if (pre_index == add_dir) k = k + 4;
      if (!add_dir) k = k - 8;
      ea = stack_ptr + k;
      bw = wb_en;
      nb = !wb_en ? stack_ptr : (add_dir ? stack_ptr + 8 : stack_ptr - 8);
    end else if (op_class == 2'd1) begin
      ea = base_val + {20'd0, imm_off};
      nb = base_val;
      bw = 1'b0;
    end else begin
      off = use_reg_off ? ref_shift(idx_reg, shift_kind, shift_amt, carry_in)
                        : {20'd0, imm_off};
      moved = add_dir ? base_val + off : base_val - off;
      ea = pre_index ? moved : base_val;
      nb = wb_en ? moved : base_val;
      bw = wb_en;
    end
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // inputs are already set; drive valid, pass one rising edge, compare at the falling edge
  task automatic apply(string tag);
    logic [31:0] ea, nb;
    logic bw;
    model(ea, nb, bw);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(tag, "out_valid", 32'(out_valid), 32'd1);
    check(tag, "eff_addr", eff_addr, ea);
    check(tag, "new_base", new_base, nb);
    check(tag, "base_wr", 32'(base_wr), 32'(bw));
  endtask

  task automatic set_req(logic [1:0] cls, logic [31:0] b, logic [31:0] sp,
                         logic [11:0] imm, logic ro, logic pre, logic add, logic wb);
    op_class = cls; base_val = b; stack_ptr = sp; imm_off = imm;
    use_reg_off = ro; pre_index = pre; add_dir = add; wb_en = wb;
  endtask

  task automatic set_shift(logic [31:0] r, logic [1:0] k, logic [4:0] a, logic c);
    idx_reg = r; shift_kind = k; shift_amt = a; carry_in = c;
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", "out_valid idle", 32'(out_valid), 32'd0);
    check("R2", "base_wr idle", 32'(base_wr), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BADF00D));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid rst", 32'(out_valid), 32'd0);
    check("R1", "base_wr rst", 32'(base_wr), 32'd0);
    check("R1", "eff_addr rst", eff_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "new_base after rst", new_base, 32'd0);
    check("R1", "out_valid after rst", 32'(out_valid), 32'd0);

    // R3 post-index, writeback R5
    set_req(2'd0, 32'h1000, 32'h0, 12'h024, 1'b0, 1'b0, 1'b1, 1'b1); apply("R3");
    // R4 pre-index subtract, no writeback
    set_req(2'd0, 32'h1000, 32'h0, 12'h010, 1'b0, 1'b1, 1'b0, 1'b0); apply("R4");
    // R5 post-index subtract with writeback on paired class
    set_req(2'd2, 32'h2000, 32'h0, 12'h008, 1'b0, 1'b0, 1'b0, 1'b1); apply("R5");
    idle_check();
    // R11 wrap-around both ways
    set_req(2'd0, 32'hFFFF_FFF0, 32'h0, 12'h020, 1'b0, 1'b1, 1'b1, 1'b1); apply("R11");
    set_req(2'd0, 32'h0000_0004, 32'h0, 12'h010, 1'b0, 1'b1, 1'b0, 1'b1); apply("R11");
    // R6 shifts
    set_req(2'd0, 32'h100, 32'h0, 12'h0, 1'b1, 1'b1, 1'b1, 1'b0);
    set_shift(32'h0000_0003, 2'd0, 5'd4, 1'b0); apply("R6");
    set_shift(32'h8000_0000, 2'd1, 5'd28, 1'b1); apply("R6");
    set_shift(32'h8000_0000, 2'd2, 5'd4, 1'b0); apply("R6");
    set_shift(32'h0000_00F1, 2'd3, 5'd4, 1'b0); apply("R6");
    set_shift(32'h0000_0040, 2'd1, 5'd0, 1'b0); apply("R6");
    // R7 rotate-with-carry
    set_shift(32'h0000_0003, 2'd3, 5'd0, 1'b1); apply("R7");
    set_shift(32'h0000_0003, 2'd3, 5'd0, 1'b0); apply("R7");
    // R8 exclusive ignores controls
    set_req(2'd1, 32'h3000, 32'h0, 12'h0FF, 1'b1, 1'b0, 1'b0, 1'b1); apply("R8");
    idle_check();
    // R9 / R10 save-state, all four index/direction combos
    for (int m = 0; m < 4; m++) begin
      set_req(2'd3, 32'h5555, 32'h8000, 12'h7, 1'b0, m[1], m[0], 1'b1); apply("R9");
    end
    set_req(2'd3, 32'h5555, 32'h8000, 12'h7, 1'b0, 1'b1, 1'b0, 1'b0); apply("R10");
    set_req(2'd3, 32'h5555, 32'h0000_0004, 12'h7, 1'b0, 1'b0, 1'b0, 1'b1); apply("R10");

    // random mix
    for (int i = 0; i < 400; i++) begin
      set_req(2'($urandom), $urandom, $urandom, 12'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom));
      set_shift($urandom, 2'($urandom), 5'($urandom), 1'($urandom));
      if (op_class == 2'd3)      apply("R9");
      else if (op_class == 2'd1) apply("R8");
      else                       apply("R4");
      if (i % 50 == 49) idle_check();
    end
    idle_check();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule